// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block drives the digital side of self-calibration for a successive-approximation converter that uses a binary-weighted capacitor DAC. A single command strobe starts one of two runs. The offset-only run measures zero error once and keeps the result as it is. The full run takes eight offset readings and averages them. It then measures each of thirteen ladder capacitors eight times against the sum of all smaller ones, and averages each group of eight.

All measurements go through an abstract request/acknowledge port. The block states what it wants measured on a selector. The analog side answers with a signed error value. Results go into one offset coefficient register and thirteen linearity coefficient registers. A constant step table with sixteen 8-bit entries drives the order of the steps.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset `busy`, `done` and `meas_req` are low, and the offset coefficient and all thirteen linearity coefficients are zero.
- R2: While idle, a cycle with `cmd_valid` high starts a run. `cmd_full`=1 selects the full run and `cmd_full`=0 selects the offset-only run. `busy` and `meas_req` are high from the next cycle.
- R3: An offset-only run makes exactly one measurement, with selector 0. Its value becomes the offset coefficient unchanged. Every linearity coefficient keeps its previous value.
- R4: A full run makes 112 measurements in a fixed order. It makes eight with selector 0 (offset), then eight with each selector k for k = 1 to 13 in ascending order (capacitor k).
- R5: Each averaged coefficient equals floor(sum of its eight samples / 8). The sum is held three bits wider than a sample, so it cannot overflow even with all samples at −512 or all at +511.
- R6: In a full run the coefficient for capacitor k lands in `lin_coef` bits [10k−1 : 10(k−1)], and the averaged offset lands in `offset_coef`.
- R7: `meas_req` stays high until a cycle where `meas_ack` is high. It is then low for exactly one cycle before the next request. Only one request is outstanding at a time.
- R8: `busy` falls in the same cycle that the last coefficient becomes visible. `done` is high for exactly that one cycle.
- R9: A `cmd_valid` that arrives while `busy` is high has no effect on the run in progress or on any coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start strobe, honoured only while idle |
| cmd_full | input | 1 | 1 = full run, 0 = offset-only run |
| meas_req | output | 1 | Measurement request |
| meas_sel | output | 4 | What to measure: 0 = offset, k = capacitor k |
| meas_ack | input | 1 | Measurement answer valid |
| meas_err | input | 10 | Signed error value returned with `meas_ack` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| offset_coef | output | 10 | Signed offset coefficient |
| lin_coef | output | 130 | Thirteen signed 10-bit linearity coefficients, capacitor 1 in the lowest slice |

## Verification
The inline assertions check the handshake shape on every cycle: the request is held until answered, a one-cycle gap follows each answer, and the selector stays stable while a request waits. They also check that `done` is a lone pulse coinciding with the fall of `busy`, that an offset-only run writes nothing but the offset slot, and that writes stay in range. The arithmetic cannot be shown by a property: floor averaging of negative sums, the extreme sample values, and the mapping from capacitor to slot. The order of the 112 measurements, the retention of the linearity bank across an offset-only run, and the rejection of commands during a run also need the bench. Its reference model predicts each of these cycle by cycle.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  localparam int STEP_DEPTH = 16;
  localparam int STEP_AW    = 4;
  localparam logic [STEP_AW-1:0] OFFSET_ONLY_ENTRY = 4'd14;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_GAP  = 2'd2
  } cal_state_t;

  // one 8-bit step entry
  typedef struct packed {
    logic                 last;    // final step of a run
    logic                 avg;     // eight samples averaged
    logic [1:0]           spare;
    logic [STEP_AW-1:0]   target;  // 0 = offset, k = capacitor k
  } cal_step_t;

endpackage

// File: rtl/cal_step_rom.sv
module cal_step_rom
  import adc_cal_pkg::*;
#(
  parameter int NUM_CAPS = 13
) (
  input  logic [STEP_AW-1:0] addr,
  output cal_step_t          step
);

  cal_step_t table_q [STEP_DEPTH];

  generate
    for (genvar i = 0; i < STEP_DEPTH; i++) begin : g_entry
      if (i == 0) begin : g_off
        assign table_q[i] = '{last: 1'b0, avg: 1'b1, spare: 2'b00, target: '0};
      end else if (i <= NUM_CAPS) begin : g_cap
        assign table_q[i] = '{last: (i == NUM_CAPS), avg: 1'b1, spare: 2'b00,
                              target: STEP_AW'(i)};
      end else begin : g_single
        assign table_q[i] = '{last: 1'b1, avg: 1'b0, spare: 2'b00, target: '0};
      end
    end
  endgenerate

  assign step = table_q[addr];

endmodule

// File: rtl/cal_averager.sv
module cal_averager #(
  parameter int SAMPLE_W = 10,
  parameter int AVG_LOG2 = 3,
  localparam int SUM_W   = SAMPLE_W + AVG_LOG2
) (
  input  logic signed [SUM_W-1:0]    acc,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       use_avg,
  output logic signed [SUM_W-1:0]    sum_next,
  output logic signed [SAMPLE_W-1:0] result
);

  logic signed [SUM_W-1:0] shifted;

  assign sum_next = acc + SUM_W'(sample);
  assign shifted  = sum_next >>> AVG_LOG2;
  assign result   = use_avg ? shifted[SAMPLE_W-1:0] : sample;

endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
  import adc_cal_pkg::*;
#(
  parameter int COEF_W   = 10,
  parameter int NUM_CAPS = 13
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [STEP_AW-1:0]         wr_idx,
  input  logic [COEF_W-1:0]          wr_data,
  output logic [COEF_W-1:0]          offset_coef,
  output logic [NUM_CAPS*COEF_W-1:0] lin_coef
);

  always_ff @(posedge clk) begin
    if (rst) offset_coef <= '0;
    else if (wr_en && wr_idx == '0) offset_coef <= wr_data;
  end

  generate
    for (genvar k = 1; k <= NUM_CAPS; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) lin_coef[(k-1)*COEF_W +: COEF_W] <= '0;
        else if (wr_en && wr_idx == STEP_AW'(k))
          lin_coef[(k-1)*COEF_W +: COEF_W] <= wr_data;
      end
    end
  endgenerate

  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx <= STEP_AW'(NUM_CAPS))); // R6

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int NUM_CAPS = 13,
  parameter int AVG_LOG2 = 3,
  localparam int SUM_W   = SAMPLE_W + AVG_LOG2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic                         cmd_full,
  output logic                         meas_req,
  output logic [STEP_AW-1:0]           meas_sel,
  input  logic                         meas_ack,
  input  logic [SAMPLE_W-1:0]          meas_err,
  output logic                         busy,
  output logic                         done,
  output logic [SAMPLE_W-1:0]          offset_coef,
  output logic [NUM_CAPS*SAMPLE_W-1:0] lin_coef
);

  cal_state_t              state;
  logic [STEP_AW-1:0]      pc;
  logic [AVG_LOG2-1:0]     cnt;
  logic signed [SUM_W-1:0] acc;
  logic                    run_full;
  cal_step_t               step;
  logic signed [SUM_W-1:0] sum_next;
  logic signed [SAMPLE_W-1:0] avg_out;
  logic                    sample_last;
  logic                    wr_en;

  cal_step_rom #(.NUM_CAPS(NUM_CAPS)) rom_i (
    .addr (pc),
    .step (step)
  );

  cal_averager #(.SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2)) avg_i (
    .acc      (acc),
    .sample   ($signed(meas_err)),
    .use_avg  (step.avg),
    .sum_next (sum_next),
    .result   (avg_out)
  );

  assign sample_last = !step.avg || (cnt == '1);
  assign wr_en       = (state == ST_MEAS) && meas_ack && sample_last;
  assign meas_sel    = step.target;

  cal_coef_bank #(.COEF_W(SAMPLE_W), .NUM_CAPS(NUM_CAPS)) bank_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_idx      (step.target),
    .wr_data     (avg_out),
    .offset_coef (offset_coef),
    .lin_coef    (lin_coef)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pc       <= '0;
      cnt      <= '0;
      acc      <= '0;
      run_full <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      meas_req <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            pc       <= cmd_full ? '0 : OFFSET_ONLY_ENTRY;
            run_full <= cmd_full;
            cnt      <= '0;
            acc      <= '0;
            busy     <= 1'b1;
            meas_req <= 1'b1;
            state    <= ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (meas_ack) begin
            meas_req <= 1'b0;
            if (sample_last) begin
              cnt <= '0;
              acc <= '0;
              if (step.last) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                pc    <= pc + 1'b1;
                state <= ST_GAP;
              end
            end else begin
              cnt   <= cnt + 1'b1;
              acc   <= sum_next;
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          meas_req <= 1'b1;
          state    <= ST_MEAS;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (meas_req && !meas_ack) |=> meas_req); // R7
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (rst)
    (meas_req && meas_ack) |=> !meas_req); // R7
  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    meas_req |-> busy); // R7
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (meas_req && !meas_ack) |=> $stable(meas_sel)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R8
  AST_OFFSET_ONLY_SLOT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !run_full) |-> (step.target == '0)); // R3

endmodule

// File: tb/adc_cal_seq_tb_top.sv
module adc_cal_seq_tb_top;

  localparam int W = 10;
  localparam int NC = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_full = 1'b0;
  logic meas_ack = 1'b0;
  logic [W-1:0] err_drv = '0;
  logic meas_req, busy, done;
  logic [3:0] meas_sel;
  logic [W-1:0] offset_coef;
  logic [NC*W-1:0] lin_coef;

  always #2.5 clk = ~clk;

  adc_cal_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_full(cmd_full),
    .meas_req(meas_req), .meas_sel(meas_sel), .meas_ack(meas_ack),
    .meas_err(err_drv), .busy(busy), .done(done),
    .offset_coef(offset_coef), .lin_coef(lin_coef)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // behavioural reference state
  bit exp_busy = 0, exp_done = 0, exp_req = 0, run_full = 0;
  int nacks = 0, total = 0, dly = 0, pat = 0, seed = 0;
  int sums [0:NC];
  int exp_off = 0;
  int exp_lin [0:NC-1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int samp(input int p, input int i);
    case (p)
      0: return ((i * 73 + 11) % 301) - 150;
      1: return -512;
      2: return 511;
      default: return (i % 2 == 1) ? 511 : -512;
    endcase
  endfunction

  function automatic int fd8(input int s);
    return (s < 0) ? (s - 7) / 8 : s / 8;
  endfunction

  function automatic int slot(input int k);
    return int'($signed(lin_coef[k*W +: W]));
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(negedge clk) begin
    bit ack_now, n_busy, n_done, n_req;
    int tgt, v;
    if (rst) begin
      meas_ack = 0; exp_busy = 0; exp_done = 0; exp_req = 0;
    end else begin
      // compare against model every cycle
      chk(busy === exp_busy, "R8", int'(busy), int'(exp_busy));
      chk(done === exp_done, "R8", int'(done), int'(exp_done));
      chk(meas_req === exp_req, "R7", int'(meas_req), int'(exp_req));
      if (exp_done) begin
        chk(int'($signed(offset_coef)) == exp_off, run_full ? "R5" : "R3",
            int'($signed(offset_coef)), exp_off);
        for (int k = 0; k < NC; k++)
          chk(slot(k) == exp_lin[k], run_full ? "R6" : "R3", slot(k), exp_lin[k]);
      end
      // responder
      ack_now = 0;
      if (meas_ack) meas_ack = 0;
      else if (meas_req && exp_busy) begin
        if (dly > 0) dly--;
        else ack_now = 1;
      end
      if (ack_now) begin
        tgt = run_full ? nacks / 8 : 0;
        chk(int'(meas_sel) == tgt, "R4", int'(meas_sel), tgt);
        v = samp(pat, nacks + seed);
        sums[tgt] += v;
        err_drv = v[W-1:0];
        meas_ack = 1;
        nacks++;
        dly = nacks % 3;
      end
      // model next state
      n_busy = exp_busy; n_done = 0; n_req = exp_req;
      if (!exp_busy) begin
        if (cmd_valid) begin
          n_busy = 1; n_req = 1; run_full = cmd_full; nacks = 0;
          total = cmd_full ? 8 * (NC + 1) : 1; dly = 1;
          for (int j = 0; j <= NC; j++) sums[j] = 0;
        end
      end else if (ack_now) begin
        n_req = 0;
        if (nacks == total) begin
          n_busy = 0; n_done = 1;
          if (run_full) begin
            exp_off = fd8(sums[0]);
            for (int k = 0; k < NC; k++) exp_lin[k] = fd8(sums[k + 1]);
          end else exp_off = sums[0];
        end
      end else if (!exp_req) n_req = 1;
      exp_busy = n_busy; exp_done = n_done; exp_req = n_req;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=busy expected=done");
      summary();
      $finish;
    end
  end

  // run one command; extra_cmd > 0 re-pulses cmd_valid that many cycles into the run
  task automatic run(input bit full, input int p, input int s, input int extra_cmd);
    int n;
    pat = p; seed = s;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_full = full;
    @(posedge clk); #1;
    cmd_valid = 0;
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
      if (extra_cmd > 0 && n == extra_cmd) begin cmd_valid = 1; cmd_full = !full; end  // R9
      else cmd_valid = 0;
    end while (exp_busy || exp_done);
    cmd_valid = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int k = 0; k < NC; k++) exp_lin[k] = 0;
    for (int j = 0; j <= NC; j++) sums[j] = 0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && meas_req === 1'b0, "R1", int'(busy), 0);
    chk(offset_coef === '0, "R1", int'(offset_coef), 0);
    chk(lin_coef === '0, "R1", int'(lin_coef != '0), 0);
    // R2/R3 offset-only
    run(1'b0, 0, 5, 0);
    // R4/R5/R6 full run with a command arriving mid-run (R9)
    run(1'b1, 0, 17, 20);
    // R5 extremes
    run(1'b1, 1, 0, 0);
    // R3 offset-only keeps the bank; second cycle of the command while busy (R9)
    run(1'b0, 2, 0, 1);
    run(1'b1, 2, 0, 0);
    run(1'b1, 3, 0, 7);
    run(1'b0, 0, 40, 0);
    summary();
    $finish;
  end

endmodule